// File: doc/BRIEF.md
# Atomic Completion Responder

This block sits behind a coherence sequencer and finishes each completed memory operation. Every completion arrives with the requester's ID, an operation kind, an address, write data, a store-conditional outcome bit and a flag saying whether the requester waits for an answer. The block decides whether backing memory must be touched. It rewrites reservation-style operations into plain ones before doing so, so memory never sees a reservation. It then either answers the requester or drops the completion without a trace.

A load-linked completion is turned into an ordinary read. A store-conditional that succeeded is turned into an ordinary write. A store-conditional that failed never reaches memory, and its answer is built inside the block. A configuration input can keep every completion off memory, in which case all answers are formed locally. Completions are handled one at a time. Backing memory is reached through a single-outstanding request/acknowledge handshake, and read data returns together with the acknowledge.

Top module: `llsc_cpl_handler`

## Requirements
- R1: While reset is held and at release, `rsp_valid` and `mem_req_valid` are low and `cpl_ready` is high once reset is released.
- R2: A store-conditional (kind 2'd3) with `cpl_sc_ok`=1 and memory enabled issues one memory write of the completion's address and data, and is answered with kind 2'd1 (write), status 1 and data 0.
- R3: A store-conditional with `cpl_sc_ok`=0 never issues a memory request, whatever `cfg_mem_en` is, and is answered with kind 2'd3, status 0 and data 0.
- R4: A load-linked (kind 2'd2) with memory enabled issues one memory read of its address and is answered with kind 2'd0 (read), status 1 and the read data returned with the acknowledge.
- R5: With `cfg_mem_en`=0 no completion issues a memory request; the answer carries the converted kind, status 1 and data 0.
- R6: With `cpl_need_rsp`=0 no response is produced, but any memory access the completion calls for still takes place.
- R7: A response appears no earlier than the cycle after the completion is accepted, and `rsp_valid` is high for exactly one cycle per response.
- R8: `cpl_ready` is low while a memory request waits for its acknowledge and while a response is being presented.
- R9: Address, data and direction of a memory request hold steady from the cycle `mem_req_valid` rises until `mem_ack` is seen.
- R10: Plain reads (2'd0) and writes (2'd1) keep their kind; a read with memory enabled returns the memory data, a write returns data 0, and both report status 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mem_en | input | 1 | Allows completions to access backing memory |
| cpl_valid | input | 1 | Completion present |
| cpl_ready | output | 1 | Block can take a completion |
| cpl_id | input | ID_W | Requester ID |
| cpl_kind | input | 2 | Operation kind: 0 read, 1 write, 2 load-linked, 3 store-conditional |
| cpl_sc_ok | input | 1 | Store-conditional succeeded |
| cpl_need_rsp | input | 1 | Requester expects a response |
| cpl_addr | input | ADDR_W | Access address |
| cpl_wdata | input | DATA_W | Write data |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Request write data |
| mem_ack | input | 1 | Memory finished the request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_id | output | ID_W | Requester ID of the response |
| rsp_kind | output | 2 | Converted operation kind |
| rsp_status | output | 1 | 0 only for a failed store-conditional |
| rsp_data | output | DATA_W | Read data or zero |

## Verification
All four kinds are sent with memory enabled, which separates the two rewrites (load-linked to read, successful store-conditional to write) from the plain pass-through and from the failed store-conditional that must stay off memory. The same kinds are repeated with memory disabled, which tells a local answer apart from a memory-backed one through the zero data and the absence of requests. Completions without a response request show that memory is still written or read while nothing comes back. A back-to-back stream with memory latencies that vary by address shows that requests stay stable under wait and that no second completion slips in while one is outstanding.

// File: rtl/llsc_cpl_pkg.sv
package llsc_cpl_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RSP  = 2'd2
    } fsm_e;

endpackage

// File: rtl/llsc_op_decode.sv
module llsc_op_decode
    import llsc_cpl_pkg::*;
(
    input  logic [1:0] kind_i,
    input  logic       sc_ok_i,
    input  logic       mem_en_i,
    output logic [1:0] kind_o,
    output logic       status_o,
    output logic       mem_use_o,
    output logic       mem_write_o
);
    logic sc_fail;

    always_comb begin
        sc_fail = (kind_i == OP_SC) && !sc_ok_i;
        unique case (kind_i)
            OP_LL:   kind_o = OP_READ;
            OP_SC:   kind_o = sc_ok_i ? OP_WRITE : OP_SC;
            default: kind_o = kind_i;
        endcase
        status_o    = !sc_fail;
        mem_use_o   = mem_en_i && !sc_fail;
        mem_write_o = (kind_o == OP_WRITE);
    end
endmodule

// File: rtl/llsc_rsp_data.sv
module llsc_rsp_data #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] data_o
);
    // Only a memory-backed read carries payload back to the requester.
    always_comb begin
        data_o = (kind_i == llsc_cpl_pkg::OP_READ) ? rdata_i : '0;
    end
endmodule

// File: rtl/llsc_cpl_handler.sv
module llsc_cpl_handler
    import llsc_cpl_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mem_en,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [ID_W-1:0]   cpl_id,
    input  logic [1:0]        cpl_kind,
    input  logic              cpl_sc_ok,
    input  logic              cpl_need_rsp,
    input  logic [ADDR_W-1:0] cpl_addr,
    input  logic [DATA_W-1:0] cpl_wdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [1:0]        rsp_kind,
    output logic              rsp_status,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        fsm_e              st;
        logic [ID_W-1:0]   id;
        logic [1:0]        kind;
        logic              status;
        logic              need;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]        dec_kind;
    logic              dec_status;
    logic              dec_mem;
    logic              dec_wr;
    logic [DATA_W-1:0] ret_data;

    llsc_op_decode u_dec (
        .kind_i      (cpl_kind),
        .sc_ok_i     (cpl_sc_ok),
        .mem_en_i    (cfg_mem_en),
        .kind_o      (dec_kind),
        .status_o    (dec_status),
        .mem_use_o   (dec_mem),
        .mem_write_o (dec_wr)
    );

    llsc_rsp_data #(.DATA_W(DATA_W)) u_data (
        .kind_i  (r_q.kind),
        .rdata_i (mem_rdata),
        .data_o  (ret_data)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cpl_valid) begin
                    r_d.id     = cpl_id;
                    r_d.kind   = dec_kind;
                    r_d.status = dec_status;
                    r_d.need   = cpl_need_rsp;
                    r_d.wr     = dec_wr;
                    r_d.addr   = cpl_addr;
                    r_d.wdata  = cpl_wdata;
                    r_d.rdata  = '0;
                    if (dec_mem) begin
                        r_d.st = ST_MEM;
                    end else if (cpl_need_rsp) begin
                        r_d.st = ST_RSP;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    r_d.rdata = ret_data;
                    r_d.st    = r_q.need ? ST_RSP : ST_IDLE;
                end
            end
            ST_RSP: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpl_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_MEM);
    assign mem_req_write = r_q.wr;
    assign mem_req_addr  = r_q.addr;
    assign mem_req_wdata = r_q.wdata;
    assign rsp_valid     = (r_q.st == ST_RSP);
    assign rsp_id        = r_q.id;
    assign rsp_kind      = r_q.kind;
    assign rsp_status    = r_q.status;
    assign rsp_data      = r_q.rdata;

endmodule

// File: rtl/llsc_cpl_handler_chk.sv
module llsc_cpl_handler_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mem_en,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic [1:0]        cpl_kind,
    input logic              cpl_sc_ok,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_ack,
    input logic              rsp_valid
);
    assert_fail_sc_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready && cpl_kind == 2'd3 && !cpl_sc_ok) |=> !mem_req_valid);

    assert_disabled_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready && !cfg_mem_en) |=> !mem_req_valid);

    assert_no_same_cycle_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |-> !rsp_valid);

    assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_while_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpl_ready);

    assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_wdata) && $stable(mem_req_write)));
endmodule

bind llsc_cpl_handler llsc_cpl_handler_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mem_en    (cfg_mem_en),
    .cpl_valid     (cpl_valid),
    .cpl_ready     (cpl_ready),
    .cpl_kind      (cpl_kind),
    .cpl_sc_ok     (cpl_sc_ok),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .rsp_valid     (rsp_valid)
);

// File: tb/tb_llsc_cpl_handler.sv
module tb_llsc_cpl_handler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mem_en = 1'b1;
    logic        cpl_valid = 1'b0;
    logic        cpl_ready;
    logic [3:0]  cpl_id = '0;
    logic [1:0]  cpl_kind = '0;
    logic        cpl_sc_ok = 1'b0;
    logic        cpl_need_rsp = 1'b0;
    logic [15:0] cpl_addr = '0;
    logic [31:0] cpl_wdata = '0;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_id;
    logic [1:0]  rsp_kind;
    logic        rsp_status;
    logic [31:0] rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_cpl_handler dut (
        .clk(clk), .rst_n(rst_n), .cfg_mem_en(cfg_mem_en),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_id(cpl_id),
        .cpl_kind(cpl_kind), .cpl_sc_ok(cpl_sc_ok), .cpl_need_rsp(cpl_need_rsp),
        .cpl_addr(cpl_addr), .cpl_wdata(cpl_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_kind(rsp_kind),
        .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    typedef struct {
        logic [3:0]  id;
        logic [1:0]  kind;
        logic        status;
        logic [31:0] data;
        int          acc;
        string       tag;
    } rsp_exp_t;

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        string       tag;
    } mem_exp_t;

    rsp_exp_t rq[$];
    mem_exp_t mq[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wcnt   = 0;
    bit done   = 1'b0;

    function automatic logic [31:0] mem_val(logic [15:0] a);
        return {a, ~a} ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) cyc++;

    task automatic send(input logic [3:0] id, input logic [1:0] kind, input logic ok,
                        input logic need, input logic en, input logic [15:0] addr,
                        input logic [31:0] wd, input string tag);
        logic       sc_fail;
        logic       use_mem;
        logic [1:0] ck;
        rsp_exp_t   re;
        mem_exp_t   me;
        sc_fail = (kind == 2'd3) && !ok;
        use_mem = en && !sc_fail;
        ck = (kind == 2'd2) ? 2'd0 : ((kind == 2'd3 && ok) ? 2'd1 : kind);
        @(negedge clk);
        while (!cpl_ready) @(negedge clk);
        cpl_valid = 1'b1; cpl_id = id; cpl_kind = kind; cpl_sc_ok = ok;
        cpl_need_rsp = need; cfg_mem_en = en; cpl_addr = addr; cpl_wdata = wd;
        if (use_mem) begin
            me.wr = (ck == 2'd1); me.addr = addr;
            me.data = wd; me.tag = tag;
            mq.push_back(me);
        end
        if (need) begin
            re.id = id; re.kind = ck; re.status = !sc_fail;
            re.data = (use_mem && ck == 2'd0) ? mem_val(addr) : 32'd0;
            re.acc = cyc; re.tag = tag;
            rq.push_back(re);
        end
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // Response monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (rq.size() == 0) begin
                fails++;
                $display("FAIL R6: response id=%0d seen, expected none", rsp_id);
            end else begin
                rsp_exp_t e;
                e = rq.pop_front();
                if ({rsp_id, rsp_kind, rsp_status, rsp_data} !== {e.id, e.kind, e.status, e.data}) begin
                    fails++;
                    $display("FAIL %s: rsp id/kind/st/data = %0d/%0d/%0d/%h expected %0d/%0d/%0d/%h",
                             e.tag, rsp_id, rsp_kind, rsp_status, rsp_data,
                             e.id, e.kind, e.status, e.data);
                end
                checks++;
                if (cyc <= e.acc) begin
                    fails++;
                    $display("FAIL R7: response in cycle %0d, expected after %0d", cyc, e.acc);
                end
            end
        end
    end

    // Backing-memory model with address-dependent latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n && mem_req_valid) begin
            checks++;
            if (cpl_ready) begin
                fails++;
                $display("FAIL R8: cpl_ready=1 during memory wait, expected 0");
            end
            checks++;
            if (mq.size() == 0) begin
                fails++;
                $display("FAIL R3/R5: memory request addr=%h seen, expected none", mem_req_addr);
            end else if ({mem_req_write, mem_req_addr, mem_req_wdata} !==
                         {mq[0].wr, mq[0].addr, (mq[0].wr ? mq[0].data : mem_req_wdata)}) begin
                fails++;
                $display("FAIL R9 %s: mem req wr/addr/data = %0d/%h/%h expected %0d/%h/%h",
                         mq[0].tag, mem_req_write, mem_req_addr, mem_req_wdata,
                         mq[0].wr, mq[0].addr, mq[0].data);
            end
            if (wcnt >= int'(mem_req_addr[1:0])) begin
                mem_ack = 1'b1;
                mem_rdata = mem_val(mem_req_addr);
                wcnt = 0;
                if (mq.size() != 0) void'(mq.pop_front());
            end else begin
                wcnt++;
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (rsp_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1: rsp_valid/mem_req_valid = %b/%b in reset, expected 0/0",
                         rsp_valid, mem_req_valid);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cpl_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: ready/rsp/mem = %b/%b/%b after reset, expected 1/0/0",
                     cpl_ready, rsp_valid, mem_req_valid);
        end

        send(4'd1, 2'd0, 1'b0, 1'b1, 1'b1, 16'h0010, 32'h0, "R10");
        send(4'd2, 2'd1, 1'b0, 1'b1, 1'b1, 16'h0021, 32'hCAFE_0001, "R10");
        send(4'd3, 2'd2, 1'b0, 1'b1, 1'b1, 16'h0102, 32'h0, "R4");
        send(4'd4, 2'd3, 1'b1, 1'b1, 1'b1, 16'h0203, 32'hBEEF_0004, "R2");
        send(4'd5, 2'd3, 1'b0, 1'b1, 1'b1, 16'h0300, 32'hDEAD_0005, "R3");
        send(4'd6, 2'd0, 1'b0, 1'b1, 1'b0, 16'h0311, 32'h0, "R5");
        send(4'd7, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0322, 32'h0, "R5");
        send(4'd8, 2'd3, 1'b1, 1'b1, 1'b0, 16'h0333, 32'h1234_5678, "R5");
        send(4'd9, 2'd3, 1'b0, 1'b1, 1'b0, 16'h0344, 32'h0, "R3");
        send(4'd10, 2'd1, 1'b0, 1'b0, 1'b1, 16'h0411, 32'hAAAA_5555, "R6");
        send(4'd11, 2'd3, 1'b0, 1'b0, 1'b1, 16'h0422, 32'h0, "R6");
        send(4'd12, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0433, 32'h0, "R6");
        send(4'd13, 2'd3, 1'b1, 1'b0, 1'b1, 16'h0443, 32'h7777_0000, "R6");
        for (int i = 0; i < 24; i++) begin
            send(4'(i), 2'(i), 1'(i >> 2), 1'b1, 1'((i % 5) != 0),
                 16'(16'h0800 + i * 7), 32'(32'h0100_0000 + i), "R7");
        end
        repeat (20) @(negedge clk);
        checks++;
        if (rq.size() != 0 || mq.size() != 0) begin
            fails++;
            $display("FAIL R6: %0d responses and %0d memory requests outstanding, expected 0/0",
                     rq.size(), mq.size());
        end
        done = 1'b1;
        summary();
    end
endmodule